// File: doc/BRIEF.md
# Actuator Control Register Bank

This block is the byte-addressed register file behind a serial-bus slave engine in a lens actuator driver. The bus engine hands it single-cycle write strobes and read requests, each with an 8-bit address. The bank holds six registers: control, coil current high bits, coil current low byte, fault status, output mode and resonance frequency. Each has a fixed value after reset. The bank drives the decoded control fields straight to the output stage and to the ringing-compensation logic.

The 10-bit coil current command is double-buffered so that the output stage never sees a half-updated value. A write to the high-bits register only stages those bits. The command changes when the low byte is written, and it then combines that byte with the staged high bits.

The fault detectors raise bits in a sticky status register. The mode controller can clear that register with a pulse, or return the whole bank to its defaults with a second pulse. Software can do the same through a self-clearing reset bit in the control register.

Top module: `actuator_regbank`

## Requirements
- R1: After reset the outputs are `coilCurrent`=0, `ringEnable`=1, `ringOnePeriod`=0, `linearMode`=0, `pwmFreqCode`=0 and `resFreq`=0x83. Reads then return 0x02 at address 0x02, 0x83 at address 0x07, and 0x00 everywhere else.
- R2: A read request with `rdEn` high returns the addressed register on `rdData` from the next clock edge. The value returned is the one before any write in the same cycle. `rdData` holds that value until the next read request.
- R3: At address 0x02, bit 1 is the ringing enable and drives `ringEnable`. Bits 7:2 ignore writes and read as 0. Bit 0 always reads as 0.
- R4: Writing 0x02 with bit 0 set returns every register to its R1 value on the next cycle, whatever the other bits of that write hold. This includes the status register and the staged high bits.
- R5: Address 0x03 bits 1:0 stage current bits 9:8 and read back as `{6'b0, staged}`. A write there leaves `coilCurrent` unchanged.
- R6: A write of byte D to address 0x04 sets `coilCurrent` to `{staged bits 9:8, D}` on the next cycle. Address 0x04 reads back D.
- R7: Address 0x05 is read-only status. Bit 0 is over-current, bit 1 is undervoltage, bit 2 is coil open, bit 3 is coil short and bit 4 is thermal shutdown. A high `faultSet[i]` sets bit i, and the bit stays set. Writes have no effect, and bits 7:5 read 0.
- R8: A `clrStatus` pulse clears the status register. A `faultSet` bit that is high in the same cycle still ends up set.
- R9: At address 0x06, bit 0 drives `ringOnePeriod` (1 = one resonance period, 0 = two), bit 1 drives `linearMode` (1 = linear, 0 = PWM) and bits 4:2 drive `pwmFreqCode`. Bits 7:5 ignore writes and read 0.
- R10: Address 0x07 is a full 8-bit read/write register driven on `resFreq`.
- R11: A `loadDefaults` pulse returns every register to its R1 value on the next cycle. It takes priority over a write and over `faultSet` in the same cycle.
- R12: Addresses 0x00, 0x01 and 0x08 to 0xFF read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Read request |
| addr | input | 8 | Register address for read or write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| faultSet | input | 5 | Fault flag set inputs, one per status bit |
| clrStatus | input | 1 | Pulse that clears the status register |
| loadDefaults | input | 1 | Pulse that restores all defaults |
| coilCurrent | output | 10 | Committed coil current command |
| ringEnable | output | 1 | Ringing compensation enable |
| ringOnePeriod | output | 1 | Ringing settling over one period when 1 |
| linearMode | output | 1 | Linear output stage when 1, PWM when 0 |
| pwmFreqCode | output | 3 | PWM frequency code |
| resFreq | output | 8 | Resonance frequency setting |

## Verification
The embedded properties check four things on every cycle:
- `coilCurrent` moves only after a low-byte commit or a default load.
- Status bits never fall except on a clear or a default load.
- A default load always lands the reset values.
- `rdData` never changes without a read request, and at most one register write strobe fires in a cycle.

Other behaviour needs the bench's scenarios:
- Bit masking on each register.
- Combining the staged high bits with a later low byte.
- A fault that arrives in the same cycle as a clear.
- The self-clearing software reset.
- Silence at unmapped addresses, checked by reading every register back afterwards.

// File: rtl/actuator_regbank_pkg.sv
package actuator_regbank_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int CUR_W   = 10;
  localparam int HI_W    = CUR_W - DATA_W;
  localparam int FAULT_W = 5;
  localparam int PWMF_W  = 3;
  localparam int MODE_W  = PWMF_W + 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h02;
  localparam logic [ADDR_W-1:0] A_CURHI = 8'h03;
  localparam logic [ADDR_W-1:0] A_CURLO = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT  = 8'h05;
  localparam logic [ADDR_W-1:0] A_MODE  = 8'h06;
  localparam logic [ADDR_W-1:0] A_FREQ  = 8'h07;

  localparam int SWRST_BIT = 0;
  localparam int RINGEN_BIT = 1;

  localparam logic              DEF_RINGEN = 1'b1;
  localparam logic [DATA_W-1:0] DEF_FREQ   = 8'h83;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_CURHI, SEL_CURLO, SEL_STAT, SEL_MODE, SEL_FREQ
  } regSelE;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrCurHi;
    logic   wrCurLo;
    logic   wrMode;
    logic   wrFreq;
    logic   loadDef;
    logic   clrStat;
    logic   rdStrobe;
    regSelE rdSel;
  } regStrbT;
endpackage

// File: rtl/actuator_regbank_ctrl.sv
module actuator_regbank_ctrl
  import actuator_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              swRstBit,
  input  logic              loadDefaults,
  input  logic              clrStatus,
  output regStrbT           strb
);
  regSelE sel;

  always_comb begin
    case (addr)
      A_CTRL:  sel = SEL_CTRL;
      A_CURHI: sel = SEL_CURHI;
      A_CURLO: sel = SEL_CURLO;
      A_STAT:  sel = SEL_STAT;
      A_MODE:  sel = SEL_MODE;
      A_FREQ:  sel = SEL_FREQ;
      default: sel = SEL_NONE;
    endcase
  end

  logic swReset;
  logic wrLive;
  assign swReset = wrEn && (sel == SEL_CTRL) && swRstBit;
  assign wrLive  = wrEn && !swReset && !loadDefaults;

  always_comb begin
    strb          = '0;
    strb.loadDef  = loadDefaults || swReset;
    strb.clrStat  = clrStatus;
    strb.rdStrobe = rdEn;
    strb.rdSel    = sel;
    strb.wrCtrl   = wrLive && (sel == SEL_CTRL);
    strb.wrCurHi  = wrLive && (sel == SEL_CURHI);
    strb.wrCurLo  = wrLive && (sel == SEL_CURLO);
    strb.wrMode   = wrLive && (sel == SEL_MODE);
    strb.wrFreq   = wrLive && (sel == SEL_FREQ);
  end

  // R12
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrCurHi, strb.wrCurLo, strb.wrMode, strb.wrFreq}));

  // R11
  def_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadDefaults |-> !(strb.wrCtrl || strb.wrCurHi || strb.wrCurLo || strb.wrMode || strb.wrFreq));
endmodule

// File: rtl/actuator_regbank_data.sv
module actuator_regbank_data
  import actuator_regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrbT            strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [FAULT_W-1:0] faultSet,
  output logic [DATA_W-1:0]  rdData,
  output logic [CUR_W-1:0]   coilCurrent,
  output logic               ringEnable,
  output logic [MODE_W-1:0]  modeBits,
  output logic [DATA_W-1:0]  resFreq
);
  logic               ringEnQ;
  logic [HI_W-1:0]    curHiQ;
  logic [DATA_W-1:0]  curLoQ;
  logic [CUR_W-1:0]   coilQ;
  logic [FAULT_W-1:0] statusQ;
  logic [MODE_W-1:0]  modeQ;
  logic [DATA_W-1:0]  freqQ;
  logic [DATA_W-1:0]  rdQ;
  logic [DATA_W-1:0]  rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringEnQ <= DEF_RINGEN;
      curHiQ  <= '0;
      curLoQ  <= '0;
      coilQ   <= '0;
      statusQ <= '0;
      modeQ   <= '0;
      freqQ   <= DEF_FREQ;
    end else if (strb.loadDef) begin
      ringEnQ <= DEF_RINGEN;
      curHiQ  <= '0;
      curLoQ  <= '0;
      coilQ   <= '0;
      statusQ <= '0;
      modeQ   <= '0;
      freqQ   <= DEF_FREQ;
    end else begin
      if (strb.wrCtrl)  ringEnQ <= wrData[RINGEN_BIT];
      if (strb.wrCurHi) curHiQ  <= wrData[HI_W-1:0];
      if (strb.wrCurLo) begin
        curLoQ <= wrData;
        coilQ  <= {curHiQ, wrData};
      end
      if (strb.wrMode)  modeQ   <= wrData[MODE_W-1:0];
      if (strb.wrFreq)  freqQ   <= wrData;
      statusQ <= (strb.clrStat ? '0 : statusQ) | faultSet;
    end
  end

  always_comb begin
    rdMux = '0;
    case (strb.rdSel)
      SEL_CTRL:  rdMux[RINGEN_BIT]   = ringEnQ;
      SEL_CURHI: rdMux[HI_W-1:0]     = curHiQ;
      SEL_CURLO: rdMux               = curLoQ;
      SEL_STAT:  rdMux[FAULT_W-1:0]  = statusQ;
      SEL_MODE:  rdMux[MODE_W-1:0]   = modeQ;
      SEL_FREQ:  rdMux               = freqQ;
      default:   rdMux               = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdQ <= '0;
    else if (strb.rdStrobe) rdQ <= rdMux;
  end

  assign rdData      = rdQ;
  assign coilCurrent = coilQ;
  assign ringEnable  = ringEnQ;
  assign modeBits    = modeQ;
  assign resFreq     = freqQ;

  // R6
  cur_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(coilCurrent) |-> $past(strb.wrCurLo || strb.loadDef));

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.clrStat || strb.loadDef) |-> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R11
  defaults_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDef |=> (resFreq == DEF_FREQ && coilCurrent == '0 && ringEnable && statusQ == '0));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.rdStrobe) |-> $stable(rdData));
endmodule

// File: rtl/actuator_regbank.sv
module actuator_regbank
  import actuator_regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [FAULT_W-1:0] faultSet,
  input  logic               clrStatus,
  input  logic               loadDefaults,
  output logic [CUR_W-1:0]   coilCurrent,
  output logic               ringEnable,
  output logic               ringOnePeriod,
  output logic               linearMode,
  output logic [PWMF_W-1:0]  pwmFreqCode,
  output logic [DATA_W-1:0]  resFreq
);
  regStrbT           strb;
  logic [MODE_W-1:0] modeBits;

  actuator_regbank_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .addr         (addr),
    .swRstBit     (wrData[SWRST_BIT]),
    .loadDefaults (loadDefaults),
    .clrStatus    (clrStatus),
    .strb         (strb)
  );

  actuator_regbank_data data_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .faultSet    (faultSet),
    .rdData      (rdData),
    .coilCurrent (coilCurrent),
    .ringEnable  (ringEnable),
    .modeBits    (modeBits),
    .resFreq     (resFreq)
  );

  assign ringOnePeriod = modeBits[0];
  assign linearMode    = modeBits[1];
  assign pwmFreqCode   = modeBits[MODE_W-1:2];
endmodule

// File: tb/actuator_regbank_tb.sv
module actuator_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0, wrData = '0;
  logic [7:0] rdData;
  logic [4:0] faultSet = '0;
  logic       clrStatus = 1'b0, loadDefaults = 1'b0;
  logic [9:0] coilCurrent;
  logic       ringEnable, ringOnePeriod, linearMode;
  logic [2:0] pwmFreqCode;
  logic [7:0] resFreq;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  actuator_regbank dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .faultSet(faultSet),
    .clrStatus(clrStatus), .loadDefaults(loadDefaults),
    .coilCurrent(coilCurrent), .ringEnable(ringEnable),
    .ringOnePeriod(ringOnePeriod), .linearMode(linearMode),
    .pwmFreqCode(pwmFreqCode), .resFreq(resFreq)
  );

  // {isWrite, req number, address, write data, expected read data}
  localparam int NV = 24;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 4'd1,  8'h02, 8'h00, 8'h02},
    {1'b0, 4'd1,  8'h07, 8'h00, 8'h83},
    {1'b0, 4'd1,  8'h05, 8'h00, 8'h00},
    {1'b1, 4'd3,  8'h02, 8'hFE, 8'h00},
    {1'b0, 4'd3,  8'h02, 8'h00, 8'h02},
    {1'b1, 4'd3,  8'h02, 8'h00, 8'h00},
    {1'b0, 4'd3,  8'h02, 8'h00, 8'h00},
    {1'b1, 4'd5,  8'h03, 8'hFF, 8'h00},
    {1'b0, 4'd5,  8'h03, 8'h00, 8'h03},
    {1'b1, 4'd6,  8'h04, 8'hA5, 8'h00},
    {1'b0, 4'd6,  8'h04, 8'h00, 8'hA5},
    {1'b1, 4'd9,  8'h06, 8'hFF, 8'h00},
    {1'b0, 4'd9,  8'h06, 8'h00, 8'h1F},
    {1'b1, 4'd9,  8'h06, 8'h09, 8'h00},
    {1'b0, 4'd9,  8'h06, 8'h00, 8'h09},
    {1'b1, 4'd10, 8'h07, 8'h5A, 8'h00},
    {1'b0, 4'd10, 8'h07, 8'h00, 8'h5A},
    {1'b1, 4'd7,  8'h05, 8'hFF, 8'h00},
    {1'b0, 4'd7,  8'h05, 8'h00, 8'h00},
    {1'b1, 4'd12, 8'h01, 8'hFF, 8'h00},
    {1'b0, 4'd12, 8'h01, 8'h00, 8'h00},
    {1'b1, 4'd12, 8'h80, 8'h33, 8'h00},
    {1'b0, 4'd12, 8'hFF, 8'h00, 8'h00},
    {1'b0, 4'd12, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic pulseFault(input logic [4:0] f, input logic clr);
    @(negedge clk);
    faultSet = f; clrStatus = clr;
    @(negedge clk);
    faultSet = '0; clrStatus = 1'b0;
  endtask

  task automatic checkDefaults(input string req);
    logic [7:0] v;
    chk(req, {22'd0, coilCurrent}, 32'h0);
    chk(req, {31'd0, ringEnable}, 32'h1);
    chk(req, {27'd0, ringOnePeriod, linearMode, pwmFreqCode}, 32'h0);
    chk(req, {24'd0, resFreq}, 32'h83);
    doRead(8'h02, v); chk(req, {24'd0, v}, 32'h02);
    doRead(8'h03, v); chk(req, {24'd0, v}, 32'h00);
    doRead(8'h04, v); chk(req, {24'd0, v}, 32'h00);
    doRead(8'h05, v); chk(req, {24'd0, v}, 32'h00);
    doRead(8'h06, v); chk(req, {24'd0, v}, 32'h00);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkDefaults("R1");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) doWrite(VEC[i][23:16], VEC[i][15:8]);
      else begin
        doRead(VEC[i][23:16], v);
        chk($sformatf("R%0d vector %0d", VEC[i][27:24], i), {24'd0, v}, {24'd0, VEC[i][7:0]});
      end
    end

    // R6 commit and R3/R9/R10 decoded outputs after the table
    chk("R6", {22'd0, coilCurrent}, 32'h3A5);
    chk("R3", {31'd0, ringEnable}, 32'h0);
    chk("R9", {27'd0, ringOnePeriod, linearMode, pwmFreqCode}, 32'b10010);
    chk("R10", {24'd0, resFreq}, 32'h5A);

    // R5 staging leaves the command alone; R6 low write combines
    doWrite(8'h03, 8'h01);
    chk("R5", {22'd0, coilCurrent}, 32'h3A5);
    doWrite(8'h04, 8'h10);
    chk("R6", {22'd0, coilCurrent}, 32'h110);

    // R12 unmapped writes touched nothing
    chk("R12", {24'd0, resFreq}, 32'h5A);

    // R7 sticky faults
    pulseFault(5'b10001, 1'b0);
    doRead(8'h05, v); chk("R7", {24'd0, v}, 32'h11);
    pulseFault(5'b00100, 1'b0);
    doRead(8'h05, v); chk("R7", {24'd0, v}, 32'h15);
    // R8 clear with simultaneous fault
    pulseFault(5'b00010, 1'b1);
    doRead(8'h05, v); chk("R8", {24'd0, v}, 32'h02);
    pulseFault(5'b00000, 1'b1);
    doRead(8'h05, v); chk("R8", {24'd0, v}, 32'h00);

    // R2 rdData holds without a read request, and same-cycle read returns old value
    doRead(8'h07, v);
    doWrite(8'h07, 8'h44);
    chk("R2", {24'd0, rdData}, 32'h5A);
    @(negedge clk);
    rdEn = 1'b1; wrEn = 1'b1; addr = 8'h07; wrData = 8'h99;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    chk("R2", {24'd0, rdData}, 32'h44);
    chk("R10", {24'd0, resFreq}, 32'h99);

    // R4 software reset restores everything, including status
    pulseFault(5'b01000, 1'b0);
    doWrite(8'h02, 8'h01);
    checkDefaults("R4");
    doRead(8'h07, v); chk("R4", {24'd0, v}, 32'h83);

    // R11 loadDefaults pulse wins over a same-cycle write and fault
    doWrite(8'h03, 8'h02);
    doWrite(8'h04, 8'h77);
    doWrite(8'h06, 8'h1E);
    doWrite(8'h02, 8'h00);
    @(negedge clk);
    loadDefaults = 1'b1; wrEn = 1'b1; addr = 8'h07; wrData = 8'h12; faultSet = 5'b11111;
    @(negedge clk);
    loadDefaults = 1'b0; wrEn = 1'b0; faultSet = '0;
    checkDefaults("R11");

    finishRun();
  end
endmodule